// File: doc/BRIEF.md
# Parallel Check-Node Update Unit for Sum-Product Decoding

This unit performs one check-node update of a sum-product low-density parity-check decoder for a check of degree nine. All nine incoming bit-to-check messages arrive together on one strobe. Nine check-to-bit messages leave together two clocks later. A new set of messages may be presented on every clock.

Every message uses sign-magnitude form. The sign of a result is the XOR of the other eight input signs. The magnitude travels through the log-tanh domain. Each input magnitude is mapped through a piecewise-linear approximation of phi(x) = -ln(tanh(x/2)). The mapped values are added once into a total. For each edge the own term is then removed from that total. The remaining residue is limited and mapped back through the same phi, which is its own inverse. Message storage and the wiring to bit nodes stay outside this unit.

Top module: `cnu_core`

## Requirements
- R1: Edge n occupies bits [9n+8:9n] of both message buses. Bit 9n+8 is the sign, where 1 means negative. Bits [9n+7:9n] are an unsigned magnitude with three integer and five fractional bits.
- R2: The transform maps an 8-bit magnitude x to an 8-bit value, using integer division with truncation:
  - x = 0 gives 255.
  - x from 1 to 7 gives 140 - 10x.
  - x from 8 to 31 gives 81 - (7x)/4.
  - x from 32 to 95 gives 36 - (11x)/32.
  - x from 96 to 127 gives 2.
  - x from 128 to 191 gives 1.
  - x from 192 to 255 gives 0.
- R3: The output sign of edge n equals the XOR of the input signs of all edges other than n.
- R4: The output magnitude of edge n is the transform of min(255, T - t_n). T is the 12-bit sum of the transformed magnitudes of all nine inputs, and t_n is the transformed magnitude of edge n. A residue below zero is taken as zero.
- R5: out_valid is high exactly two rising edges after a rising edge at which in_valid was sampled high. Consecutive input sets are accepted on consecutive clocks.
- R6: While out_valid is low, out_msg keeps the value it last carried.
- R7: While rst_n is low, out_valid and out_msg are driven to zero.
- R8: A zero input magnitude transforms to the largest value, 255. When every input magnitude is zero, every residue exceeds 255 and is limited to 255, so every output magnitude is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks in_msg as a valid set of nine messages |
| in_msg | input | 81 | Nine bit-to-check messages, edge n at [9n+8:9n] |
| out_valid | output | 1 | Marks out_msg as a fresh set of results |
| out_msg | output | 81 | Nine check-to-bit messages, edge n at [9n+8:9n] |

## Verification
The bench builds the unit with its default degree of nine, a 12-bit accumulator and an 8-bit magnitude. This makes the worst-case sum of 2295 fit the accumulator without wrapping. It also exposes the saturation of residues between 255 and 2040 whenever inputs are weak. Directed sets place one lane at each breakpoint of the transform while the other lanes sit at 255. In that setting the neighbouring outputs show the double transform of a single input. Random sets, with gaps in the valid strobe, check the odd-degree sign rule and show that results hold between strobes.

// File: rtl/cnu_pkg.sv
// Package cnu_pkg
// Shared constants and the piecewise-linear log-tanh transform used on both
// sides of the magnitude path. Assumes a 3.5 fixed-point 8-bit magnitude.
package cnu_pkg;

    localparam int MAG_W = 8;
    localparam int MSG_W = MAG_W + 1;
    localparam logic [MAG_W-1:0] MAG_MAX = {MAG_W{1'b1}};

    // Piecewise-linear approximation of -ln(tanh(x/2)) on 3.5 fixed point.
    function automatic logic [MAG_W-1:0] cnu_phi(input logic [MAG_W-1:0] x);
        logic [11:0] xe;
        logic [11:0] t;
        xe = {4'd0, x};
        t  = 12'd0;
        if (x == 8'd0)
            t = 12'd255;
        else if (x < 8'd8)
            t = 12'd140 - (xe * 12'd10);
        else if (x < 8'd32)
            t = 12'd81 - ((xe * 12'd7) >> 2);
        else if (x < 8'd96)
            t = 12'd36 - ((xe * 12'd11) >> 5);
        else if (x < 8'd128)
            t = 12'd2;
        else if (x < 8'd192)
            t = 12'd1;
        else
            t = 12'd0;
        return t[MAG_W-1:0];
    endfunction

endpackage

// File: rtl/cnu_phi_bank.sv
// Module cnu_phi_bank
// Applies the log-tanh transform to DEG magnitudes in parallel.
// Purely combinational; the caller registers the result.
module cnu_phi_bank #(
    parameter int DEG = 9
) (
    input  logic [DEG*cnu_pkg::MAG_W-1:0] mag_in,
    output logic [DEG*cnu_pkg::MAG_W-1:0] phi_out
);
    import cnu_pkg::*;

    for (genvar g = 0; g < DEG; g++) begin : g_lane
        // Map one lane's magnitude into the log-tanh domain.
        always_comb begin
            phi_out[g*MAG_W +: MAG_W] = cnu_phi(mag_in[g*MAG_W +: MAG_W]);
        end
    end

endmodule

// File: rtl/cnu_sign_net.sv
// Module cnu_sign_net
// Produces each edge's extrinsic sign as the XOR of all other signs by
// removing the own sign from the full parity. Purely combinational.
module cnu_sign_net #(
    parameter int DEG = 9
) (
    input  logic [DEG-1:0] sgn_in,
    output logic [DEG-1:0] sgn_out
);
    logic parity;

    // Full parity over all incoming signs.
    always_comb begin
        parity = ^sgn_in;
    end

    for (genvar g = 0; g < DEG; g++) begin : g_lane
        // Remove the own sign from the full parity.
        always_comb begin
            sgn_out[g] = parity ^ sgn_in[g];
        end
    end

endmodule

// File: rtl/cnu_residue.sv
// Module cnu_residue
// Total-sum-first magnitude stage: one sum of all transformed inputs, one
// subtraction per edge, clamp below zero, limit to the magnitude range,
// then the inverse transform (the same function). Combinational.
// Assumes ACC_W is wide enough for DEG * MAG_MAX.
module cnu_residue #(
    parameter int DEG   = 9,
    parameter int ACC_W = 12
) (
    input  logic [DEG*cnu_pkg::MAG_W-1:0] phi_in,
    output logic [DEG*cnu_pkg::MAG_W-1:0] mag_out
);
    import cnu_pkg::*;

    localparam int DIF_W = ACC_W + 1;
    localparam logic [ACC_W-1:0] SAT_LIM = ACC_W'(MAG_MAX);

    logic [ACC_W-1:0] total;

    // Accumulate every transformed input once.
    always_comb begin
        total = '0;
        for (int i = 0; i < DEG; i++) begin
            total = total + ACC_W'(phi_in[i*MAG_W +: MAG_W]);
        end
    end

    for (genvar g = 0; g < DEG; g++) begin : g_lane
        logic signed [DIF_W-1:0] diff;
        logic [ACC_W-1:0]        res;
        logic [MAG_W-1:0]        lim;

        // Remove own term, clamp at zero, limit to magnitude range.
        always_comb begin
            diff = $signed({1'b0, total}) -
                   $signed({1'b0, ACC_W'(phi_in[g*MAG_W +: MAG_W])});
            if (diff < 0)
                res = '0;
            else
                res = diff[ACC_W-1:0];
            if (res > SAT_LIM)
                lim = MAG_MAX;
            else
                lim = res[MAG_W-1:0];
        end

        // Map the residue back out of the log-tanh domain.
        always_comb begin
            mag_out[g*MAG_W +: MAG_W] = cnu_phi(lim);
        end
    end

endmodule

// File: rtl/cnu_core.sv
// Module cnu_core
// Degree-DEG sum-product check-node update. Stage 1 registers the transformed
// magnitudes and the signs; stage 2 registers the recombined results.
// Latency is two clocks, one input set per clock. Synchronous active-low reset.
module cnu_core #(
    parameter int DEG   = 9,
    parameter int ACC_W = 12
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    input  logic [DEG*cnu_pkg::MSG_W-1:0]   in_msg,
    output logic                            out_valid,
    output logic [DEG*cnu_pkg::MSG_W-1:0]   out_msg
);
    import cnu_pkg::*;

    localparam int MAGS_W = DEG * MAG_W;

    logic [MAGS_W-1:0] in_mag;
    logic [DEG-1:0]    in_sgn;
    logic [MAGS_W-1:0] phi_now;
    logic [MAGS_W-1:0] s1_phi;
    logic [DEG-1:0]    s1_sgn;
    logic              s1_vld;
    logic [DEG-1:0]    ext_sgn;
    logic [MAGS_W-1:0] ext_mag;
    logic [DEG*MSG_W-1:0] result;

    // Split each input message into sign and magnitude.
    always_comb begin
        for (int i = 0; i < DEG; i++) begin
            in_sgn[i]                 = in_msg[i*MSG_W + MAG_W];
            in_mag[i*MAG_W +: MAG_W]  = in_msg[i*MSG_W +: MAG_W];
        end
    end

    cnu_phi_bank #(.DEG(DEG)) u_fwd (
        .mag_in  (in_mag),
        .phi_out (phi_now)
    );

    // Stage 1 register: transformed magnitudes, raw signs, strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_phi <= '0;
            s1_sgn <= '0;
            s1_vld <= 1'b0;
        end else begin
            s1_vld <= in_valid;
            if (in_valid) begin
                s1_phi <= phi_now;
                s1_sgn <= in_sgn;
            end
        end
    end

    cnu_sign_net #(.DEG(DEG)) u_sgn (
        .sgn_in  (s1_sgn),
        .sgn_out (ext_sgn)
    );

    cnu_residue #(.DEG(DEG), .ACC_W(ACC_W)) u_res (
        .phi_in  (s1_phi),
        .mag_out (ext_mag)
    );

    // Recombine sign and magnitude per edge.
    always_comb begin
        for (int i = 0; i < DEG; i++) begin
            result[i*MSG_W +: MSG_W] = {ext_sgn[i], ext_mag[i*MAG_W +: MAG_W]};
        end
    end

    // Stage 2 register: results held until the next strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_msg   <= '0;
        end else begin
            out_valid <= s1_vld;
            if (s1_vld)
                out_msg <= result;
        end
    end

endmodule

// File: rtl/cnu_core_chk.sv
// Module cnu_core_chk
// Port-level properties of cnu_core, attached by bind.
module cnu_core_chk #(
    parameter int DEG = 9
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic [DEG*9-1:0]       in_msg,
    input logic                   out_valid,
    input logic [DEG*9-1:0]       out_msg
);
    logic [DEG-1:0] i_sg;
    logic [DEG-1:0] o_sg;

    // Gather sign bits from both buses.
    always_comb begin
        for (int i = 0; i < DEG; i++) begin
            i_sg[i] = in_msg[i*9 + 8];
            o_sg[i] = out_msg[i*9 + 8];
        end
    end

    // R5: a sampled strobe yields a result strobe two edges later
    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid, 2) && $past(rst_n, 1) && $past(rst_n, 2)) |-> out_valid);

    // R5: no result strobe without a strobe two edges earlier
    p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(in_valid, 2) && $past(rst_n, 1) && $past(rst_n, 2)) |-> !out_valid);

    // R3: parity of extrinsic signs over all edges follows the degree parity
    p_sign_parity_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(rst_n, 2)) |->
            ((^o_sg) == (((DEG % 2) == 0) ? ^$past(i_sg, 2) : 1'b0)));

    // R6: results hold while no strobe is present
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_msg));

    // R7: reset leaves outputs cleared on the next edge
    always @(posedge clk) begin
        if (rst_n && $past(!rst_n)) begin
            p_reset_clear_r7: assert (!out_valid && out_msg == '0);
        end
    end

endmodule

bind cnu_core cnu_core_chk #(.DEG(DEG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_msg    (in_msg),
    .out_valid (out_valid),
    .out_msg   (out_msg)
);

// File: tb/cnu_core_test.sv
// Bench for cnu_core: directed corner sets plus seeded random sets, each
// result compared against a reference model built from the requirements.
module cnu_core_test;
    localparam int CLK_P = 10;
    localparam int DEG   = 9;
    localparam int W     = DEG * 9;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_msg = '0;
    logic         out_valid;
    logic [W-1:0] out_msg;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic         d1_v = 1'b0, d2_v = 1'b0;
    logic [W-1:0] d1_m = '0, d2_m = '0;
    logic [W-1:0] last_exp = '0;

    cnu_core #(.DEG(DEG), .ACC_W(12)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_msg(in_msg),
        .out_valid(out_valid), .out_msg(out_msg)
    );

    always #(CLK_P/2) clk = ~clk;

    // R2 reference transform
    function automatic int phi_ref(input int x);
        if (x == 0)        return 255;
        else if (x <= 7)   return 140 - 10 * x;
        else if (x <= 31)  return 81 - (7 * x) / 4;
        else if (x <= 95)  return 36 - (11 * x) / 32;
        else if (x <= 127) return 2;
        else if (x <= 191) return 1;
        else               return 0;
    endfunction

    // R3/R4 reference for a full message set
    function automatic logic [W-1:0] model(input logic [W-1:0] m);
        logic [W-1:0] r;
        int total, res, par;
        total = 0; par = 0;
        for (int i = 0; i < DEG; i++) begin
            total += phi_ref(int'(m[i*9 +: 8]));
            par ^= int'(m[i*9 + 8]);
        end
        for (int i = 0; i < DEG; i++) begin
            res = total - phi_ref(int'(m[i*9 +: 8]));
            if (res < 0) res = 0;
            if (res > 255) res = 255;
            r[i*9 +: 8] = 8'(phi_ref(res));
            r[i*9 + 8]  = 1'(par ^ int'(m[i*9 + 8]));
        end
        return r;
    endfunction

    function automatic logic [DEG-1:0] signs_of(input logic [W-1:0] m);
        logic [DEG-1:0] s;
        for (int i = 0; i < DEG; i++) s[i] = m[i*9 + 8];
        return s;
    endfunction

    function automatic logic [W-1:0] mags_of(input logic [W-1:0] m);
        logic [W-1:0] r;
        r = m;
        for (int i = 0; i < DEG; i++) r[i*9 + 8] = 1'b0;
        return r;
    endfunction

    // One cycle: check outputs due now, then drive the next input set.
    task automatic step(input logic v, input logic [W-1:0] m);
        logic [W-1:0] e;
        @(negedge clk);
        checks++;
        if (out_valid !== d2_v) begin
            errors++;
            $display("FAIL R5 out_valid actual=%0b expected=%0b", out_valid, d2_v);
        end
        if (d2_v) begin
            e = model(d2_m);
            last_exp = e;
            checks++;
            if (signs_of(out_msg) !== signs_of(e)) begin
                errors++;
                $display("FAIL R1 R3 signs actual=%h expected=%h", signs_of(out_msg), signs_of(e));
            end
            checks++;
            if (mags_of(out_msg) !== mags_of(e)) begin
                errors++;
                $display("FAIL R2 R4 R8 magnitudes actual=%h expected=%h", mags_of(out_msg), mags_of(e));
            end
        end else begin
            checks++;
            if (out_msg !== last_exp) begin
                errors++;
                $display("FAIL R6 hold actual=%h expected=%h", out_msg, last_exp);
            end
        end
        d2_v = d1_v; d2_m = d1_m;
        d1_v = v;    d1_m = m;
        in_valid = v;
        in_msg   = m;
    endtask

    function automatic logic [W-1:0] fill(input logic [8:0] lane0, input logic [8:0] rest);
        logic [W-1:0] r;
        for (int i = 0; i < DEG; i++) r[i*9 +: 9] = (i == 0) ? lane0 : rest;
        return r;
    endfunction

    initial begin
        int pts[12];
        logic [W-1:0] m;
        pts = '{0, 1, 7, 8, 31, 32, 95, 96, 127, 128, 191, 255};
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_msg !== '0) begin
            errors++;
            $display("FAIL R7 reset actual=%0b/%h expected=0/0", out_valid, out_msg);
        end
        @(negedge clk);
        rst_n = 1'b1;
        // R8: all magnitudes zero, mixed signs
        step(1'b1, fill(9'h100, 9'h000));
        step(1'b1, fill(9'h000, 9'h000));
        // R8: one zero lane among strong lanes
        step(1'b1, fill(9'h000, 9'h0FF));
        // R2: each breakpoint in lane 0, others neutral
        foreach (pts[k]) step(1'b1, fill(9'(pts[k]), 9'h0FF));
        // R5: gaps in the strobe, R6 hold
        step(1'b0, '0);
        step(1'b0, fill(9'h1AA, 9'h055));
        step(1'b1, fill(9'h105, 9'h10A));
        step(1'b0, '0);
        // Random sets mixing weak and strong magnitudes
        for (int n = 0; n < 400; n++) begin
            for (int i = 0; i < DEG; i++) begin
                int sel;
                sel = int'($urandom_range(0, 3));
                if (sel == 0) m[i*9 +: 8] = 8'($urandom_range(0, 7));
                else if (sel == 1) m[i*9 +: 8] = 8'($urandom_range(8, 40));
                else m[i*9 +: 8] = 8'($urandom_range(0, 255));
                m[i*9 + 8] = 1'($urandom_range(0, 1));
            end
            step(($urandom_range(0, 3) != 0), m);
        end
        step(1'b0, '0);
        step(1'b0, '0);
        step(1'b0, '0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule